// File: doc/BRIEF.md
# Dual Comparator Output Conditioning and Interrupt Logic

This block is the digital side of a pair of analog comparators. Each comparator's raw decision arrives as one asynchronous bit. The block brings it into the system clock domain and conditions it with the comparator's enable and polarity controls. It then reports the result as a status bit, and as a mirror copy for a second register view. The result reaches an output pin only when the pin is allowed to drive. The second comparator's reported output can optionally be re-timed to the falling edge of a timer clock.

Any change in either reported output sets one shared change flag, which software must clear. The flag becomes an interrupt request only when three enable levels are all open. The block also passes the channel-select and reference-select fields straight to the analog multiplexers, which sit outside it.

Top module: `dcmp_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every registered state clears. After reset, `cmp_out`, `mirror_out`, `pin_out`, `chg_flag` and `irq` are 0 until a stimulus changes them.
- R2: A comparator whose `cmp_en` bit is 0 reports 0 on its `cmp_out` bit and its `pin_out` bit. Changes on its raw input never set `chg_flag`.
- R3: `raw_dec` passes through a two-flop synchronizer. With `cmp_pol` bit 0, an enabled comparator reports its synchronized raw bit. With `cmp_pol` bit 1, it reports the inverse, so a 1 means the non-inverting input is lower. Bit 0 of each vector is comparator 1 and bit 1 is comparator 2.
- R4: `pin_en` bit i is 1 exactly when `cmp_en`, `cmp_oe` and not `pin_dir` all hold for comparator i, where a `pin_dir` bit of 0 means output. `pin_out` bit i equals `cmp_out` bit i when `pin_en` bit i is set, and is 0 otherwise.
- R5: `c1_inv_sel` and `c2_inv_sel` carry the 2-bit inverting-input codes 0 to 3 unchanged. `ninv_sel` bit i carries the reference-select bit of comparator i, where 1 picks the reference voltage and 0 picks the external pin.
- R6: `mirror_out` always equals `cmp_out`.
- R7: With `sync_en` at 1, comparator 2 reports a value captured only when a falling edge of `tmr_clk` is seen. `tmr_clk` is itself two-flop synchronized. The reported value holds between such edges. With `sync_en` at 0, comparator 2 passes through unsynchronized.
- R8: A change of either enabled comparator's reported output sets `chg_flag` at the next clock edge. The flag stays set until `flag_clr` is pulsed.
- R9: A change of a comparator's enable, polarity or sync selection does not set `chg_flag` in the cycle it takes effect.
- R10: When `flag_clr` is high in the same cycle that a change is detected, `chg_flag` is set rather than cleared.
- R11: `irq` is 1 exactly when `chg_flag`, `cmp_ie`, `periph_ie` and `global_ie` are all 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_dec | input | 2 | Asynchronous raw comparator decisions |
| cmp_en | input | 2 | Per-comparator enable |
| cmp_pol | input | 2 | Per-comparator output inversion |
| cmp_oe | input | 2 | Per-comparator pin output enable |
| pin_dir | input | 2 | Pin direction, 0 = output |
| c1_chan | input | 2 | Comparator 1 inverting-input code |
| c2_chan | input | 2 | Comparator 2 inverting-input code |
| ref_pick | input | 2 | Per-comparator non-inverting source select |
| sync_en | input | 1 | Re-time comparator 2 to timer falling edge |
| tmr_clk | input | 1 | Timer clock, sampled |
| flag_clr | input | 1 | Software clear of the change flag |
| cmp_ie | input | 1 | Comparator interrupt enable |
| periph_ie | input | 1 | Peripheral interrupt enable |
| global_ie | input | 1 | Global interrupt enable |
| cmp_out | output | 2 | Conditioned comparator status |
| mirror_out | output | 2 | Mirror copy of the status |
| pin_en | output | 2 | Pin driver enable |
| pin_out | output | 2 | Pin data |
| c1_inv_sel | output | 2 | Multiplexer code, comparator 1 inverting input |
| c2_inv_sel | output | 2 | Multiplexer code, comparator 2 inverting input |
| ninv_sel | output | 2 | Multiplexer select, non-inverting inputs |
| chg_flag | output | 1 | Shared change flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a clear that collides with a set. The software clear must land in the single cycle where a change is being detected, and that cycle comes two synchronizer stages after the raw input moves. The bench toggles the raw input on a falling clock edge and counts two rising edges. It then raises `flag_clr` for exactly the cycle in which the change is visible. The timer re-timing case is reached in a similar way. The bench holds `tmr_clk` high while the raw input moves and confirms the status holds, then lowers it and waits through the timer synchronizer before it expects the update.

// File: rtl/dcmp_pkg.sv
// Shared constants and types for the dual comparator control block.
package dcmp_pkg;
    localparam int NUM_CMP = 2;   // number of comparator lanes
    localparam int CH_W    = 2;   // width of an inverting-input code

    // Per-lane control fields used by the conditioning logic.
    typedef struct packed {
        logic en;    // lane enable
        logic pol;   // 1 = invert reported output
        logic oe;    // allow output to a pin
        logic dir;   // pin direction, 0 = output
    } lane_cfg_t;
endpackage

// File: rtl/dcmp_sync.sv
// Two-flop synchronizer for a vector of independent asynchronous bits.
// Assumes each bit is a level; no relation between bits is preserved.
module dcmp_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Capture the asynchronous level twice to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;
endmodule

// File: rtl/dcmp_lane.sv
// One comparator lane: polarity, enable, optional timer re-timing,
// pin gating and change detection. Assumes dec_s is already in the
// clk domain and tmr_fall is a one-cycle pulse per timer falling edge.
module dcmp_lane
    import dcmp_pkg::*;
#(
    parameter bit HAS_TSYNC = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      dec_s,
    input  lane_cfg_t cfg,
    input  logic      tsync_en,
    input  logic      tmr_fall,
    output logic      out,
    output logic      pin_en,
    output logic      pin_val,
    output logic      chg
);
    logic      direct;
    logic      selected;
    logic      prev_q;
    lane_cfg_t cfg_q;
    logic      tsync_q;
    logic      reload;

    assign direct = dec_s ^ cfg.pol;

    generate
        if (HAS_TSYNC) begin : g_tsync
            logic hold_q;
            // Sample the conditioned decision on each timer falling edge.
            always_ff @(posedge clk) begin
                if (!rst_n)        hold_q <= 1'b0;
                else if (tmr_fall) hold_q <= direct;
            end
            assign selected = tsync_en ? hold_q : direct;
        end else begin : g_direct
            logic unused_tsync;
            assign unused_tsync = tsync_en ^ tmr_fall;
            assign selected     = direct;
        end
    endgenerate

    assign out     = cfg.en & selected;
    assign pin_en  = cfg.en & cfg.oe & ~cfg.dir;
    assign pin_val = pin_en & out;

    // Keep last cycle's output and controls for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            cfg_q   <= '0;
            tsync_q <= 1'b0;
        end else begin
            prev_q  <= out;
            cfg_q   <= cfg;
            tsync_q <= tsync_en;
        end
    end

    assign reload = (cfg_q.en != cfg.en) | (cfg_q.pol != cfg.pol) | (tsync_q != tsync_en);
    assign chg    = cfg.en & (out != prev_q) & ~reload;

    // R2: a disabled lane reports nothing and flags nothing
    a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |-> (!out && !pin_val && !chg));
    // R4: pin carries the status only when every qualifier allows it
    a_r4_pin_gate: assert property (@(posedge clk) disable iff (!rst_n)
        pin_val |-> (out && cfg.en && cfg.oe && !cfg.dir));
    // R9: turning a lane on never raises a change in that cycle
    a_r9_enable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg.en) |-> !chg);
endmodule

// File: rtl/dcmp_flag.sv
// Shared change flag with software clear and three-level interrupt gate.
// Assumes chg bits are single-cycle detections in the clk domain.
module dcmp_flag
    import dcmp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CMP-1:0] chg,
    input  logic               flag_clr,
    input  logic               cmp_ie,
    input  logic               periph_ie,
    input  logic               global_ie,
    output logic               flag,
    output logic               irq
);
    logic set;
    assign set = |chg;

    // Set wins over clear; otherwise hold until software clears.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (set)      flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    assign irq = flag & cmp_ie & periph_ie & global_ie;

    // R8: a detected change sets the flag at the next edge
    a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
    // R8: the flag stays set until cleared
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);
    // R10: a clear without a change empties the flag
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !set) |=> !flag);
    // R11: no request without the flag and all enables
    a_r11_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && cmp_ie && periph_ie && global_ie));
endmodule

// File: rtl/dcmp_ctrl.sv
// Top of the dual comparator control block. Synchronizes raw decisions
// and the timer clock, runs one lane per comparator (the last lane may
// be re-timed to the timer), and merges changes into one flag.
// Assumes the analog parts read the select outputs directly.
module dcmp_ctrl
    import dcmp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CMP-1:0] raw_dec,
    input  logic [NUM_CMP-1:0] cmp_en,
    input  logic [NUM_CMP-1:0] cmp_pol,
    input  logic [NUM_CMP-1:0] cmp_oe,
    input  logic [NUM_CMP-1:0] pin_dir,
    input  logic [CH_W-1:0]    c1_chan,
    input  logic [CH_W-1:0]    c2_chan,
    input  logic [NUM_CMP-1:0] ref_pick,
    input  logic               sync_en,
    input  logic               tmr_clk,
    input  logic               flag_clr,
    input  logic               cmp_ie,
    input  logic               periph_ie,
    input  logic               global_ie,
    output logic [NUM_CMP-1:0] cmp_out,
    output logic [NUM_CMP-1:0] mirror_out,
    output logic [NUM_CMP-1:0] pin_en,
    output logic [NUM_CMP-1:0] pin_out,
    output logic [CH_W-1:0]    c1_inv_sel,
    output logic [CH_W-1:0]    c2_inv_sel,
    output logic [NUM_CMP-1:0] ninv_sel,
    output logic               chg_flag,
    output logic               irq
);
    localparam int SYNC_W = NUM_CMP + 1;

    logic [SYNC_W-1:0]  sync_q;
    logic [NUM_CMP-1:0] dec_s;
    logic               tmr_s;
    logic               tmr_d;
    logic               tmr_fall;
    logic [NUM_CMP-1:0] chg;

    dcmp_sync #(.W(SYNC_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({tmr_clk, raw_dec}),
        .d_sync  (sync_q)
    );

    assign dec_s = sync_q[NUM_CMP-1:0];
    assign tmr_s = sync_q[NUM_CMP];

    // Delay the synchronized timer clock to find its falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) tmr_d <= 1'b0;
        else        tmr_d <= tmr_s;
    end

    assign tmr_fall = tmr_d & ~tmr_s;

    generate
        for (genvar i = 0; i < NUM_CMP; i++) begin : g_lane
            lane_cfg_t cfg;
            assign cfg = '{en: cmp_en[i], pol: cmp_pol[i], oe: cmp_oe[i], dir: pin_dir[i]};
            dcmp_lane #(.HAS_TSYNC(i == NUM_CMP - 1)) u_lane (
                .clk      (clk),
                .rst_n    (rst_n),
                .dec_s    (dec_s[i]),
                .cfg      (cfg),
                .tsync_en (sync_en),
                .tmr_fall (tmr_fall),
                .out      (cmp_out[i]),
                .pin_en   (pin_en[i]),
                .pin_val  (pin_out[i]),
                .chg      (chg[i])
            );
        end
    endgenerate

    assign mirror_out = cmp_out;
    assign c1_inv_sel = c1_chan;
    assign c2_inv_sel = c2_chan;
    assign ninv_sel   = ref_pick;

    dcmp_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .chg       (chg),
        .flag_clr  (flag_clr),
        .cmp_ie    (cmp_ie),
        .periph_ie (periph_ie),
        .global_ie (global_ie),
        .flag      (chg_flag),
        .irq       (irq)
    );

    // R7: with re-timing on, comparator 2 holds unless a timer fall was taken
    a_r7_retime_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && $past(sync_en) && !$past(tmr_fall) &&
         cmp_en[NUM_CMP-1] && $past(cmp_en[NUM_CMP-1]))
        |-> $stable(cmp_out[NUM_CMP-1]));
    // R1: the timer edge detector is idle right after reset
    a_r1_no_fall_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !tmr_fall);
endmodule

// File: tb/tb_dcmp_ctrl.sv
`timescale 1ns/1ps
module tb_dcmp_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] raw_dec, cmp_en, cmp_pol, cmp_oe, pin_dir, c1_chan, c2_chan, ref_pick;
    logic       sync_en, tmr_clk, flag_clr, cmp_ie, periph_ie, global_ie;
    logic [1:0] cmp_out, mirror_out, pin_en, pin_out, c1_inv_sel, c2_inv_sel, ninv_sel;
    logic       chg_flag, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dcmp_ctrl dut (
        .clk(clk), .rst_n(rst_n), .raw_dec(raw_dec), .cmp_en(cmp_en),
        .cmp_pol(cmp_pol), .cmp_oe(cmp_oe), .pin_dir(pin_dir),
        .c1_chan(c1_chan), .c2_chan(c2_chan), .ref_pick(ref_pick),
        .sync_en(sync_en), .tmr_clk(tmr_clk), .flag_clr(flag_clr),
        .cmp_ie(cmp_ie), .periph_ie(periph_ie), .global_ie(global_ie),
        .cmp_out(cmp_out), .mirror_out(mirror_out), .pin_en(pin_en),
        .pin_out(pin_out), .c1_inv_sel(c1_inv_sel), .c2_inv_sel(c2_inv_sel),
        .ninv_sel(ninv_sel), .chg_flag(chg_flag), .irq(irq)
    );

    // {en, pol, oe, dir, raw, exp_out, exp_pin_en}, bit0 = comparator 1
    localparam logic [13:0] VEC [8] = '{
        {2'b11, 2'b00, 2'b11, 2'b00, 2'b01, 2'b01, 2'b11},
        {2'b11, 2'b11, 2'b11, 2'b00, 2'b01, 2'b10, 2'b11},
        {2'b01, 2'b00, 2'b11, 2'b00, 2'b11, 2'b01, 2'b01},
        {2'b10, 2'b01, 2'b11, 2'b00, 2'b00, 2'b00, 2'b10},
        {2'b11, 2'b10, 2'b01, 2'b00, 2'b00, 2'b10, 2'b01},
        {2'b11, 2'b00, 2'b11, 2'b10, 2'b11, 2'b11, 2'b01},
        {2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00},
        {2'b11, 2'b01, 2'b10, 2'b01, 2'b10, 2'b11, 2'b10}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; raw_dec = 2'b11; cmp_en = 2'b11; cmp_pol = 2'b00;
        cmp_oe = 2'b11; pin_dir = 2'b00; c1_chan = 2'd0; c2_chan = 2'd0;
        ref_pick = 2'b00; sync_en = 1'b0; tmr_clk = 1'b1; flag_clr = 1'b0;
        cmp_ie = 1'b1; periph_ie = 1'b1; global_ie = 1'b1;
        wait_n(3);
        // R1: synchronizer still cleared while reset holds
        chk("R1 cmp_out", cmp_out, 2'b00);
        chk("R1 pin_out", pin_out, 2'b00);
        chk("R1 flag", chg_flag, 1'b0);
        chk("R1 irq", irq, 1'b0);
        raw_dec = 2'b00;
        rst_n = 1'b1;
        wait_n(4);

        // R3 R4 R6: table walk
        for (int k = 0; k < 8; k++) begin
            {cmp_en, cmp_pol, cmp_oe, pin_dir, raw_dec} = VEC[k][13:4];
            wait_n(4);
            chk("R3 cmp_out", cmp_out, VEC[k][3:2]);
            chk("R6 mirror", mirror_out, VEC[k][3:2]);
            chk("R4 pin_en", pin_en, VEC[k][1:0]);
            chk("R4 pin_out", pin_out, VEC[k][3:2] & VEC[k][1:0]);
        end

        // R5: select codes pass through
        c1_chan = 2'd2; c2_chan = 2'd3; ref_pick = 2'b01;
        wait_n(1);
        chk("R5 c1 code", c1_inv_sel, 2'd2);
        chk("R5 c2 code", c2_inv_sel, 2'd3);
        chk("R5 ref select", ninv_sel, 2'b01);

        // baseline: both on, no inversion, inputs low, flag cleared
        cmp_en = 2'b11; cmp_pol = 2'b00; raw_dec = 2'b00; pin_dir = 2'b00; cmp_oe = 2'b11;
        wait_n(4);
        flag_clr = 1'b1; wait_n(1); flag_clr = 1'b0; wait_n(1);
        chk("R8 cleared", chg_flag, 1'b0);

        // R8: change sets flag and it holds
        raw_dec[0] = 1'b1;
        wait_n(4);
        chk("R8 set", chg_flag, 1'b1);
        wait_n(5);
        chk("R8 hold", chg_flag, 1'b1);

        // R11: interrupt gate
        chk("R11 all on", irq, 1'b1);
        global_ie = 1'b0; wait_n(1); chk("R11 global off", irq, 1'b0);
        global_ie = 1'b1; periph_ie = 1'b0; wait_n(1); chk("R11 periph off", irq, 1'b0);
        periph_ie = 1'b1; cmp_ie = 1'b0; wait_n(1); chk("R11 cmp off", irq, 1'b0);
        cmp_ie = 1'b1;

        // R10: clear in the very cycle a change is detected
        raw_dec[0] = 1'b0;
        wait_n(2);
        flag_clr = 1'b1;
        wait_n(1);
        flag_clr = 1'b0;
        chk("R10 set beats clear", chg_flag, 1'b1);
        flag_clr = 1'b1; wait_n(1); flag_clr = 1'b0;
        chk("R10 plain clear", chg_flag, 1'b0);
        chk("R11 no flag", irq, 1'b0);

        // R9: polarity flip changes output but not the flag
        cmp_pol[0] = 1'b1;
        wait_n(4);
        chk("R9 pol out", cmp_out[0], 1'b1);
        chk("R9 pol no flag", chg_flag, 1'b0);
        // R9: enabling a lane whose input is high
        cmp_en[1] = 1'b0; raw_dec[1] = 1'b1;
        wait_n(4);
        chk("R2 off out", cmp_out[1], 1'b0);
        chk("R2 off no flag", chg_flag, 1'b0);
        cmp_en[1] = 1'b1;
        wait_n(3);
        chk("R9 enable out", cmp_out[1], 1'b1);
        chk("R9 enable no flag", chg_flag, 1'b0);

        // R2: disabled lane ignores raw toggles
        cmp_en[0] = 1'b0;
        wait_n(2);
        raw_dec[0] = 1'b1; wait_n(4); raw_dec[0] = 1'b0; wait_n(4);
        chk("R2 toggles ignored", chg_flag, 1'b0);
        chk("R2 pin quiet", pin_out[0], 1'b0);

        // R7: timer re-timing of comparator 2
        raw_dec[1] = 1'b0;
        wait_n(4);
        tmr_clk = 1'b0; wait_n(5); tmr_clk = 1'b1; wait_n(5);
        sync_en = 1'b1;
        wait_n(3);
        chk("R7 captured low", cmp_out[1], 1'b0);
        raw_dec[1] = 1'b1;
        wait_n(6);
        chk("R7 holds w/o edge", cmp_out[1], 1'b0);
        tmr_clk = 1'b0;
        wait_n(5);
        chk("R7 updates on fall", cmp_out[1], 1'b1);
        chk("R8 retimed change", chg_flag, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule